// File: doc/BRIEF.md
# SPI Slave Byte Transceiver

This block is a byte-wide SPI slave that lives in a fast system clock domain. The external SCK, MOSI and NSS lines are brought in through two-flop synchronizers, and SCK edges are found from the synchronized samples. Because of this, SCK must run slower than one quarter of the system clock.

The slave uses SPI mode 0. MOSI is captured on the SCK rising edge and MISO changes on the falling edge, most significant bit first. The slave never starts a transfer; the external master drives all shifting.

A received byte lands in a read register and raises a completion flag. That flag stays set until the host clears it, and an overrun flag records a byte that arrives while the flag is still set. Transmit data passes through a single holding slot in front of the shift register, so the host can queue the next byte while the current one is still being clocked out.

A stored configuration field selects the slave type. In 4-wire operation a low NSS enables the slave, and a falling NSS restarts the byte. In 3-wire operation NSS is ignored, and only cycling the enable input restarts the byte. Any configuration value other than `2'b00` behaves as 4-wire.

Top module: `spis_top`

## Requirements
- R1: After reset, `done_o`, `ovr_o`, `rd_data_o` and `miso_oe_o` are all 0, and the configuration is 4-wire (`2'b01`).
- R2: MOSI is sampled MSB first on each SCK rising edge. After the 8th rising edge, `rd_data_o` holds the byte and `done_o` is 1, both within three system clocks of that SCK edge at the pin.
- R3: `done_o` stays 1 until `clr_i` is pulsed. `clr_i` clears both `done_o` and `ovr_o`.
- R4: If a byte completes while `done_o` is 1, `ovr_o` becomes 1 and `rd_data_o` takes the new byte.
- R5: A `tx_wr_i` write while the shifter is empty goes straight into the shifter. Empty means no byte is loaded and no byte is in progress. Its MSB appears on `miso_o` on the next clock, and each SCK falling edge inside a byte moves out the next lower bit.
- R6: A write while the shifter is loaded goes to the holding slot, and a later write replaces the slot's contents. The slot moves into the shifter when the current byte's 8th bit completes.
- R7: When a byte finishes and the holding slot is empty, `miso_o` drives 0, and the next byte sends all zeros.
- R8: With configuration bit 0 or bit 1 set (4-wire), the slave is active only while NSS is low. While NSS is high, `miso_oe_o` is 0 and SCK edges do not change `done_o` or `rd_data_o`. A falling NSS discards a partially received byte.
- R9: With configuration `2'b00` (3-wire), NSS is ignored and `miso_oe_o` is 1 whenever `en_i` is 1. NSS toggles do not restart a partial byte. A low `en_i` does restart it, so the next completion needs 8 fresh SCK rising edges.
- R10: While `en_i` is 0, `miso_oe_o` is 0 and SCK edges neither complete a byte nor change `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Slave enable; low clears the bit counter |
| cfg_wr_i | input | 1 | Stores `cfg_mode_i` into the configuration field |
| cfg_mode_i | input | 2 | 2'b00 selects 3-wire; any other value selects 4-wire |
| tx_wr_i | input | 1 | Transmit data write strobe |
| tx_data_i | input | DATA_W | Transmit data |
| clr_i | input | 1 | Clears completion and overrun flags |
| rd_data_o | output | DATA_W | Last received byte |
| done_o | output | 1 | Byte completion flag |
| ovr_o | output | 1 | Receive overrun flag |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| nss_i | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO |

## Verification
Each pin change on SCK, MOSI or NSS takes effect on the third system clock edge after it is driven: two synchronizer stages, then the register update. The bench holds every SCK phase for four system clocks and samples outputs at falling clock edges. As a result, MISO is read four clocks after the preceding SCK fall, and `done_o` and `rd_data_o` are read four clocks after the last SCK rise, one cycle past their due time. A host write moves `miso_o` on the next clock edge, so MISO is sampled one falling clock edge after the write strobe drops.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef enum logic [1:0] {
    MODE_3W = 2'b00,
    MODE_4W = 2'b01
  } spis_mode_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spis_bitctl.sv
module spis_bitctl #(
  parameter int W = 8,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         four_wire_i,
  input  logic         sck_s_i,
  input  logic         mosi_s_i,
  input  logic         nss_s_i,
  output logic         active_o,
  output logic         tx_shift_o,
  output logic         mid_byte_o,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             sck_q, nss_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     rx_sh_q;
  logic             sck_rise, sck_fall, nss_fall, restart, take_bit;

  assign sck_rise = sck_s_i & ~sck_q;
  assign sck_fall = ~sck_s_i & sck_q;
  assign nss_fall = ~nss_s_i & nss_q;
  assign active_o = en_i & (~four_wire_i | ~nss_s_i);
  assign restart  = ~en_i | (four_wire_i & nss_fall);
  assign take_bit = ~restart & active_o & sck_rise;

  assign mid_byte_o  = (cnt_q != '0);
  assign tx_shift_o  = active_o & sck_fall & mid_byte_o;
  assign byte_done_o = take_bit & (cnt_q == LAST);
  assign byte_o      = {rx_sh_q[W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      nss_q   <= 1'b1;
      cnt_q   <= '0;
      rx_sh_q <= '0;
    end else begin
      sck_q <= sck_s_i;
      nss_q <= nss_s_i;
      if (restart) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        rx_sh_q <= {rx_sh_q[W-2:0], mosi_s_i};
        cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  p_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_nss_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && four_wire_i && nss_fall) |=> (cnt_q == '0));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && en_i && !nss_fall) |=> $stable(cnt_q));
endmodule

// File: rtl/spis_txpath.sv
module spis_txpath #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         shift_i,
  input  logic         mid_byte_i,
  input  logic         byte_done_i,
  output logic         miso_o
);
  logic [W-1:0] tx_sh_q, hold_q;
  logic         loaded_q, hold_full_q;
  logic         empty;

  assign empty  = ~loaded_q & ~mid_byte_i;
  assign miso_o = tx_sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q     <= '0;
      hold_q      <= '0;
      loaded_q    <= 1'b0;
      hold_full_q <= 1'b0;
    end else if (byte_done_i) begin
      if (hold_full_q) begin
        tx_sh_q     <= hold_q;
        loaded_q    <= 1'b1;
        hold_full_q <= wr_i;
        if (wr_i) hold_q <= wr_data_i;
      end else if (wr_i) begin
        tx_sh_q  <= wr_data_i;
        loaded_q <= 1'b1;
      end else begin
        tx_sh_q  <= '0;
        loaded_q <= 1'b0;
      end
    end else begin
      if (shift_i) tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
      if (wr_i) begin
        if (empty) begin
          tx_sh_q  <= wr_data_i;
          loaded_q <= 1'b1;
        end else begin
          hold_q      <= wr_data_i;
          hold_full_q <= 1'b1;
        end
      end
    end
  end

  p_empty_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && empty && !byte_done_i) |=> (loaded_q && tx_sh_q == $past(wr_data_i)));
  p_hold_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && hold_full_q) |=> (loaded_q && tx_sh_q == $past(hold_q)));
  p_drain_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && !hold_full_q && !wr_i) |=> (!loaded_q && !miso_o));
endmodule

// File: rtl/spis_rxregs.sv
module spis_rxregs #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_done_i,
  input  logic [W-1:0] byte_i,
  input  logic         clr_i,
  output logic [W-1:0] rd_data_o,
  output logic         done_o,
  output logic         ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      done_o    <= 1'b0;
      ovr_o     <= 1'b0;
    end else if (byte_done_i) begin
      rd_data_o <= byte_i;
      done_o    <= 1'b1;
      if (clr_i)       ovr_o <= 1'b0;
      else if (done_o) ovr_o <= 1'b1;
    end else if (clr_i) begin
      done_o <= 1'b0;
      ovr_o  <= 1'b0;
    end
  end

  p_done_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> (done_o && rd_data_o == $past(byte_i)));
  p_done_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !byte_done_i) |=> (!done_o && !ovr_o));
  p_ovr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && done_o && !clr_i) |=> ovr_o);
endmodule

// File: rtl/spis_top.sv
module spis_top
  import spis_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              ovr_o,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              nss_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  spis_mode_e        mode_q;
  logic              four_wire;
  logic [2:0]        pins_s;
  logic              active, tx_shift, mid_byte, byte_done;
  logic [DATA_W-1:0] rx_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_4W;
    else if (cfg_wr_i) mode_q <= spis_mode_e'(cfg_mode_i);
  end

  assign four_wire = (mode_q != MODE_3W);

  // bit order: {nss, mosi, sck}; nss idles high
  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({nss_i, mosi_i, sck_i}),
    .q_o    (pins_s)
  );

  spis_bitctl #(.W(DATA_W)) u_bitctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .four_wire_i (four_wire),
    .sck_s_i     (pins_s[0]),
    .mosi_s_i    (pins_s[1]),
    .nss_s_i     (pins_s[2]),
    .active_o    (active),
    .tx_shift_o  (tx_shift),
    .mid_byte_o  (mid_byte),
    .byte_done_o (byte_done),
    .byte_o      (rx_byte)
  );

  spis_txpath #(.W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (tx_wr_i),
    .wr_data_i   (tx_data_i),
    .shift_i     (tx_shift),
    .mid_byte_i  (mid_byte),
    .byte_done_i (byte_done),
    .miso_o      (miso_o)
  );

  spis_rxregs #(.W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .clr_i       (clr_i),
    .rd_data_o   (rd_data_o),
    .done_o      (done_o),
    .ovr_o       (ovr_o)
  );

  assign miso_oe_o = active;

  p_oe_nss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (four_wire && pins_s[2]) |-> !miso_oe_o);
  p_oe_3w_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!four_wire && en_i) |-> miso_oe_o);
  p_quiet_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(rd_data_o) && !ovr_o || $past(ovr_o)));
endmodule

// File: tb/spis_top_tb.sv
module spis_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PH = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         cfg_wr_i = 1'b0;
  logic [1:0]   cfg_mode_i = 2'b01;
  logic         tx_wr_i = 1'b0;
  logic [W-1:0] tx_data_i = '0;
  logic         clr_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         done_o, ovr_o;
  logic         sck_i = 1'b0;
  logic         mosi_i = 1'b0;
  logic         nss_i = 1'b1;
  logic         miso_o, miso_oe_o;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spis_top #(.DATA_W(W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_wr_i(cfg_wr_i),
    .cfg_mode_i(cfg_mode_i), .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i),
    .clr_i(clr_i), .rd_data_o(rd_data_o), .done_o(done_o), .ovr_o(ovr_o),
    .sck_i(sck_i), .mosi_i(mosi_i), .nss_i(nss_i), .miso_o(miso_o),
    .miso_oe_o(miso_oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic bit bit_of(input logic [W-1:0] v, input int i);
    return v[i];
  endfunction

  task automatic sck_bit(input bit b, input bit chk_en, input bit exp, input string req);
    mosi_i = b;
    tick(PH);
    if (chk_en) chk(miso_o == exp, req, "miso bit", miso_o, exp);
    sck_i = 1'b1;
    tick(PH);
    sck_i = 1'b0;
  endtask

  task automatic xfer(input logic [W-1:0] rx, input bit chk_tx,
                      input logic [W-1:0] tx, input string req);
    for (int i = W-1; i >= 0; i--) sck_bit(rx[i], chk_tx, bit_of(tx, i), req);
    tick(PH);
  endtask

  task automatic host_wr(input logic [W-1:0] d);
    tx_wr_i = 1'b1; tx_data_i = d;
    tick(1);
    tx_wr_i = 1'b0;
    tick(1);
  endtask

  task automatic host_clr();
    clr_i = 1'b1; tick(1); clr_i = 1'b0; tick(1);
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_wr_i = 1'b1; cfg_mode_i = m; tick(1); cfg_wr_i = 1'b0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] tx, rx;
    void'($urandom(32'h5eed_0042));
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R1
    chk(done_o == 0, "R1", "done", done_o, 0);
    chk(ovr_o == 0, "R1", "ovr", ovr_o, 0);
    chk(rd_data_o == 0, "R1", "rd", rd_data_o, 0);
    chk(miso_oe_o == 0, "R1", "oe", miso_oe_o, 0);
    en_i = 1'b1;
    tick(PH);
    chk(miso_oe_o == 0, "R1", "oe 4-wire nss high", miso_oe_o, 0);
    nss_i = 1'b0;
    tick(PH);
    chk(miso_oe_o == 1, "R8", "oe nss low", miso_oe_o, 1);

    // R5, R2
    host_wr(8'hA5);
    chk(miso_o == 1, "R5", "msb after write", miso_o, 1);
    xfer(8'h3C, 1'b1, 8'hA5, "R5");
    chk(done_o == 1, "R2", "done", done_o, 1);
    chk(rd_data_o == 8'h3C, "R2", "rd", rd_data_o, 8'h3C);
    chk(ovr_o == 0, "R2", "no ovr", ovr_o, 0);
    chk(miso_o == 0, "R7", "miso idle", miso_o, 0);

    // R3
    tick(10);
    chk(done_o == 1, "R3", "done held", done_o, 1);
    host_clr();
    chk(done_o == 0, "R3", "done cleared", done_o, 0);

    // R4, R7
    xfer(8'h11, 1'b1, 8'h00, "R7");
    chk(done_o == 1 && ovr_o == 0, "R4", "first done", {done_o, ovr_o}, 2);
    xfer(8'h22, 1'b0, 8'h00, "R4");
    chk(ovr_o == 1, "R4", "ovr", ovr_o, 1);
    chk(rd_data_o == 8'h22, "R4", "rd overwritten", rd_data_o, 8'h22);
    host_clr();
    chk(ovr_o == 0 && done_o == 0, "R3", "clr both", {done_o, ovr_o}, 0);

    // R6
    host_wr(8'h81);
    host_wr(8'h7E);
    host_wr(8'hC3);
    chk(miso_o == 1, "R6", "first byte msb", miso_o, 1);
    xfer(8'h01, 1'b1, 8'h81, "R6");
    chk(miso_o == 1, "R6", "hold msb", miso_o, 1);
    host_clr();
    xfer(8'h02, 1'b1, 8'hC3, "R6");
    host_clr();
    xfer(8'h03, 1'b1, 8'h00, "R7");
    host_clr();

    // R8
    nss_i = 1'b1;
    tick(PH);
    chk(miso_oe_o == 0, "R8", "oe nss high", miso_oe_o, 0);
    xfer(8'h55, 1'b0, 8'h00, "R8");
    chk(done_o == 0, "R8", "ignored done", done_o, 0);
    chk(rd_data_o == 8'h03, "R8", "ignored rd", rd_data_o, 8'h03);
    nss_i = 1'b0; tick(PH);
    for (int i = 0; i < 3; i++) sck_bit(1'b1, 1'b0, 1'b0, "R8");
    nss_i = 1'b1; tick(PH);
    nss_i = 1'b0; tick(PH);
    xfer(8'h96, 1'b0, 8'h00, "R8");
    chk(done_o == 1, "R8", "done after restart", done_o, 1);
    chk(rd_data_o == 8'h96, "R8", "rd after restart", rd_data_o, 8'h96);
    host_clr();

    // R9
    set_mode(2'b00);
    nss_i = 1'b1;
    tick(PH);
    chk(miso_oe_o == 1, "R9", "oe 3-wire", miso_oe_o, 1);
    xfer(8'h6B, 1'b0, 8'h00, "R9");
    chk(rd_data_o == 8'h6B && done_o, "R9", "rx nss high", rd_data_o, 8'h6B);
    host_clr();
    for (int i = 7; i >= 5; i--) sck_bit(bit_of(8'hE7, i), 1'b0, 1'b0, "R9");
    nss_i = 1'b0; tick(PH);
    nss_i = 1'b1; tick(PH);
    for (int i = 4; i >= 0; i--) sck_bit(bit_of(8'hE7, i), 1'b0, 1'b0, "R9");
    tick(PH);
    chk(rd_data_o == 8'hE7, "R9", "nss toggle kept bits", rd_data_o, 8'hE7);
    host_clr();
    for (int i = 0; i < 3; i++) sck_bit(1'b0, 1'b0, 1'b0, "R9");
    en_i = 1'b0; tick(3);
    chk(miso_oe_o == 0, "R10", "oe disabled", miso_oe_o, 0);
    en_i = 1'b1; tick(PH);
    for (int i = 7; i >= 1; i--) sck_bit(bit_of(8'h5A, i), 1'b0, 1'b0, "R9");
    tick(PH);
    chk(done_o == 0, "R9", "no early done", done_o, 0);
    sck_bit(bit_of(8'h5A, 0), 1'b0, 1'b0, "R9");
    tick(PH);
    chk(rd_data_o == 8'h5A && done_o, "R9", "fresh byte", rd_data_o, 8'h5A);
    host_clr();

    // R10
    set_mode(2'b01);
    nss_i = 1'b0;
    en_i = 1'b0;
    tick(PH);
    chk(miso_oe_o == 0, "R10", "oe off", miso_oe_o, 0);
    xfer(8'hF0, 1'b0, 8'h00, "R10");
    chk(done_o == 0, "R10", "no done", done_o, 0);
    chk(rd_data_o == 8'h5A, "R10", "rd kept", rd_data_o, 8'h5A);
    en_i = 1'b1;
    tick(PH);

    // random traffic, 4-wire
    for (int n = 0; n < 24; n++) begin
      tx = W'($urandom);
      rx = W'($urandom);
      host_wr(tx);
      chk(miso_o == tx[W-1], "R5", "rand msb", miso_o, tx[W-1]);
      xfer(rx, 1'b1, tx, "R5");
      chk(done_o == 1, "R2", "rand done", done_o, 1);
      chk(rd_data_o == rx, "R2", "rand rd", rd_data_o, rx);
      chk(ovr_o == 0, "R4", "rand no ovr", ovr_o, 0);
      host_clr();
    end

    ended = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule